// File: doc/BRIEF.md
# Excess-Three Decimal and Binary ALU

This block is the arithmetic-logic unit of a 20-bit word machine with 10-bit bytes. It takes two 20-bit operands, a carry input and a 4-bit operation code. It returns a 20-bit result together with carry, zero and negative flags. It provides a pass-through load, three bitwise operations, four binary add and subtract forms, and two decimal additions on excess-three coded digits. Each decimal addition treats the word as five 4-bit digits.

Wider integers, such as 40-bit binary or ten-digit decimal values, are handled one word at a time. Software feeds the carry flag of one word into the carry input of the next word's with-carry operation. The arithmetic itself is combinational. A single output register stage, with a synchronous active-low reset, presents the result and flags one clock after the operands are sampled.

Top module: `xs3_alu`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, `result_o`, `carry_o`, `zero_o` and `neg_o` all become 0.
- R2: Outputs change only at a rising clock edge. After the edge they reflect the inputs sampled at that edge, so there is one cycle of latency.
- R3: Code 0 returns operand B. Codes 10 to 15 return operand A unchanged.
- R4: Code 1 returns A AND B. Code 2 returns A OR B. Code 3 returns the equivalence of A and B, which is bitwise XNOR.
- R5: Code 4 returns A+B, with the carry taken out of bit 19 and the carry input ignored. Code 6 returns A+B+carry input.
- R6: Code 5 returns A+~B+1, and code 7 returns A+~B+carry input. For both, carry out set means no borrow occurred.
- R7: Code 8 adds five excess-three digits held in bits [4k+3:4k], where a digit stores its value plus 3. It ignores the carry input. The carry out is the carry from the top digit, and each digit's carry feeds the digit above it.
- R8: Code 9 performs the same decimal addition as code 8, but adds the carry input into the lowest digit. For example, 99999 plus 00000 with the carry input set gives 00000 with carry out set.
- R9: The carry flag is 0 for codes 0 to 3 and for codes 10 to 15.
- R10: The zero flag is 1 exactly when all 20 result bits are 0. The negative flag equals result bit 19.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_i | input | 4 | Operation code |
| a_i | input | 20 | Operand A |
| b_i | input | 20 | Operand B |
| carry_i | input | 1 | Carry input for the with-carry forms |
| result_o | output | 20 | Registered result |
| carry_o | output | 1 | Registered carry flag |
| zero_o | output | 1 | Registered zero flag |
| neg_o | output | 1 | Registered negative flag |

## Verification
Fixed vectors drive each code with operand patterns that separate the operations from one another. The complementary nibble masks F0F0F and 3C3C3 give different answers for AND, OR and XNOR. The operands FFFFF+1 and 3-5 expose carry wrap and borrow polarity. Pairs with the carry input set and cleared show whether the with-carry forms honour it and the plain forms ignore it.

For decimal addition, the all-nines operand plus a carry-in ripples a correction through all five digits. Random valid excess-three operands are compared with a model that converts to integers and back, which catches any digit whose +3 or -3 correction is wrong.

// File: rtl/xs3alu_pkg.sv
// Shared widths and operation codes for the decimal/binary ALU.
// Assumes the word width is a whole multiple of the digit width.
package xs3alu_pkg;
    localparam int WORD_W     = 20;
    localparam int DIGIT_W    = 4;
    localparam int NUM_DIGITS = WORD_W / DIGIT_W;
    localparam int OP_W       = 4;

    typedef enum logic [OP_W-1:0] {
        OP_LDB  = 4'd0,
        OP_AND  = 4'd1,
        OP_OR   = 4'd2,
        OP_EQV  = 4'd3,
        OP_ADD  = 4'd4,
        OP_SUB  = 4'd5,
        OP_ADC  = 4'd6,
        OP_SBC  = 4'd7,
        OP_DAD  = 4'd8,
        OP_DADC = 4'd9
    } op_e;
endpackage

// File: rtl/xs3alu_logic.sv
// Bitwise unit: selects pass-B, AND, OR or XNOR by a 2-bit select.
// Assumes the select is taken from the low bits of the operation code.
module xs3alu_logic #(
    parameter int WIDTH = xs3alu_pkg::WORD_W
) (
    input  logic [1:0]       sel_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] y_o
);
    // Pick one bitwise function of the two operands.
    always_comb begin
        unique case (sel_i)
            2'd0:    y_o = b_i;
            2'd1:    y_o = a_i & b_i;
            2'd2:    y_o = a_i | b_i;
            default: y_o = ~(a_i ^ b_i);
        endcase
    end
endmodule

// File: rtl/xs3alu_binadd.sv
// Binary adder with optional inversion of B; subtract is A + ~B + cin.
// Assumes the caller chooses the carry input (0, 1 or the external carry).
module xs3alu_binadd #(
    parameter int WIDTH = xs3alu_pkg::WORD_W
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             invert_b_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o
);
    logic [WIDTH-1:0] b_eff;
    logic [WIDTH:0]   full;

    // Form the effective B and the widened sum.
    always_comb begin
        b_eff = invert_b_i ? ~b_i : b_i;
        full  = {1'b0, a_i} + {1'b0, b_eff} + {{WIDTH{1'b0}}, cin_i};
    end

    assign sum_o  = full[WIDTH-1:0];
    assign cout_o = full[WIDTH];
endmodule

// File: rtl/xs3alu_decadd.sv
// Excess-three decimal adder: one ripple stage per digit. Each digit is
// added in binary, then corrected by +3 on a digit carry or -3 otherwise.
// Assumes operands hold valid excess-three digits (codes 3 to 12).
module xs3alu_decadd #(
    parameter int WIDTH   = xs3alu_pkg::WORD_W,
    parameter int DIGIT_W = xs3alu_pkg::DIGIT_W
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o
);
    localparam int NDIG = WIDTH / DIGIT_W;
    localparam logic [DIGIT_W-1:0] BIAS = DIGIT_W'(3);

    logic [NDIG:0] dcarry;

    assign dcarry[0] = cin_i;

    for (genvar k = 0; k < NDIG; k++) begin : g_digit
        logic [DIGIT_W:0]   raw;
        logic [DIGIT_W-1:0] lo;

        // Binary add of one digit pair plus the carry from below.
        always_comb begin
            raw = {1'b0, a_i[k*DIGIT_W +: DIGIT_W]}
                + {1'b0, b_i[k*DIGIT_W +: DIGIT_W]}
                + {{DIGIT_W{1'b0}}, dcarry[k]};
            lo  = raw[DIGIT_W-1:0];
        end

        assign dcarry[k+1] = raw[DIGIT_W];
        assign sum_o[k*DIGIT_W +: DIGIT_W] = raw[DIGIT_W] ? (lo + BIAS) : (lo - BIAS);
    end

    assign cout_o = dcarry[NDIG];
endmodule

// File: rtl/xs3_alu.sv
// Top of the ALU: decodes the operation, steers operands into the logic,
// binary and decimal units, forms the flags and registers all outputs.
// Assumes a synchronous active-low reset; codes 10 to 15 pass A through.
module xs3_alu
    import xs3alu_pkg::*;
#(
    parameter int WIDTH   = WORD_W,
    parameter int DIGIT_W = xs3alu_pkg::DIGIT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OP_W-1:0]  op_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             carry_i,
    output logic [WIDTH-1:0] result_o,
    output logic             carry_o,
    output logic             zero_o,
    output logic             neg_o
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] logic_y, bin_sum, dec_sum, res_c;
    logic             bin_inv, bin_cin, bin_cout, dec_cin, dec_cout, carry_c;

    xs3alu_logic #(.WIDTH(WIDTH)) u_logic (
        .sel_i (op_i[1:0]),
        .a_i   (a_i),
        .b_i   (b_i),
        .y_o   (logic_y)
    );

    xs3alu_binadd #(.WIDTH(WIDTH)) u_binadd (
        .a_i        (a_i),
        .b_i        (b_i),
        .invert_b_i (bin_inv),
        .cin_i      (bin_cin),
        .sum_o      (bin_sum),
        .cout_o     (bin_cout)
    );

    xs3alu_decadd #(.WIDTH(WIDTH), .DIGIT_W(DIGIT_W)) u_decadd (
        .a_i    (a_i),
        .b_i    (b_i),
        .cin_i  (dec_cin),
        .sum_o  (dec_sum),
        .cout_o (dec_cout)
    );

    // Choose adder controls from the operation code.
    always_comb begin
        bin_inv = (op_i == OP_SUB) || (op_i == OP_SBC);
        unique case (op_i)
            OP_SUB:         bin_cin = 1'b1;
            OP_ADC, OP_SBC: bin_cin = carry_i;
            default:        bin_cin = 1'b0;
        endcase
        dec_cin = (op_i == OP_DADC) ? carry_i : 1'b0;
    end

    // Select the result and carry for the current operation.
    always_comb begin
        unique case (op_i)
            OP_LDB, OP_AND, OP_OR, OP_EQV: begin
                res_c   = logic_y;
                carry_c = 1'b0;
            end
            OP_ADD, OP_SUB, OP_ADC, OP_SBC: begin
                res_c   = bin_sum;
                carry_c = bin_cout;
            end
            OP_DAD, OP_DADC: begin
                res_c   = dec_sum;
                carry_c = dec_cout;
            end
            default: begin
                res_c   = a_i;
                carry_c = 1'b0;
            end
        endcase
    end

    // Register result and flags; clear them on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o <= '0;
            carry_o  <= 1'b0;
            zero_o   <= 1'b0;
            neg_o    <= 1'b0;
        end else begin
            result_o <= res_c;
            carry_o  <= carry_c;
            zero_o   <= ~|res_c;
            neg_o    <= res_c[MSB];
        end
    end
endmodule

// File: rtl/xs3_alu_chk.sv
// Property checker for xs3_alu, attached by bind. Relates registered
// outputs to the inputs sampled one edge earlier.
module xs3_alu_chk
    import xs3alu_pkg::*;
#(
    parameter int WIDTH = WORD_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic [OP_W-1:0]  op_i,
    input logic [WIDTH-1:0] a_i,
    input logic [WIDTH-1:0] b_i,
    input logic [WIDTH-1:0] result_o,
    input logic             carry_o,
    input logic             zero_o,
    input logic             neg_o
);
    p_load_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_LDB) |=> (result_o == $past(b_i)));

    p_unused_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i > OP_DADC) |=> (result_o == $past(a_i)));

    p_and_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_AND) |=> (result_o == ($past(a_i) & $past(b_i))));

    p_eqv_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_EQV) |=> (result_o == ~($past(a_i) ^ $past(b_i))));

    p_no_carry_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_i <= OP_EQV) || (op_i > OP_DADC)) |=> !carry_o);

    p_zero_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (zero_o == (result_o == '0)));

    p_neg_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (neg_o == result_o[WIDTH-1]));
endmodule

bind xs3_alu xs3_alu_chk #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_i     (op_i),
    .a_i      (a_i),
    .b_i      (b_i),
    .result_o (result_o),
    .carry_o  (carry_o),
    .zero_o   (zero_o),
    .neg_o    (neg_o)
);

// File: tb/xs3_alu_tb.sv
module xs3_alu_tb;
    typedef struct packed {
        logic [3:0]  op;
        logic [19:0] a;
        logic [19:0] b;
        logic        cin;
        logic [19:0] res;
        logic        c;
    } vec_t;

    localparam int NVEC = 18;
    localparam vec_t VECS [NVEC] = '{
        '{4'd0,  20'h12345, 20'hABCDE, 1'b1, 20'hABCDE, 1'b0},
        '{4'd1,  20'hF0F0F, 20'h3C3C3, 1'b1, 20'h30303, 1'b0},
        '{4'd2,  20'hF0F0F, 20'h3C3C3, 1'b1, 20'hFCFCF, 1'b0},
        '{4'd3,  20'hF0F0F, 20'h3C3C3, 1'b0, 20'h33333, 1'b0},
        '{4'd4,  20'hFFFFF, 20'h00001, 1'b1, 20'h00000, 1'b1},
        '{4'd4,  20'h12345, 20'h11111, 1'b0, 20'h23456, 1'b0},
        '{4'd5,  20'h00005, 20'h00003, 1'b0, 20'h00002, 1'b1},
        '{4'd5,  20'h00003, 20'h00005, 1'b1, 20'hFFFFE, 1'b0},
        '{4'd6,  20'hFFFFF, 20'h00000, 1'b1, 20'h00000, 1'b1},
        '{4'd6,  20'h00010, 20'h00020, 1'b1, 20'h00031, 1'b0},
        '{4'd7,  20'h00005, 20'h00003, 1'b0, 20'h00001, 1'b1},
        '{4'd7,  20'h00000, 20'h00000, 1'b0, 20'hFFFFF, 1'b0},
        '{4'd8,  20'h45678, 20'h44444, 1'b1, 20'h56789, 1'b0},
        '{4'd8,  20'hCCCCC, 20'h33334, 1'b0, 20'h33333, 1'b1},
        '{4'd9,  20'hCCCCC, 20'h33333, 1'b1, 20'h33333, 1'b1},
        '{4'd9,  20'h45678, 20'h33333, 1'b1, 20'h45679, 1'b0},
        '{4'd15, 20'hABCDE, 20'h12345, 1'b1, 20'hABCDE, 1'b0},
        '{4'd10, 20'h00000, 20'hFFFFF, 1'b1, 20'h00000, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op = 4'd0;
    logic [19:0] a = '0, b = '0;
    logic        cin = 1'b0;
    logic [19:0] result;
    logic        carry, zero, neg;
    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    xs3_alu u_dut (
        .clk(clk), .rst_n(rst_n), .op_i(op), .a_i(a), .b_i(b), .carry_i(cin),
        .result_o(result), .carry_o(carry), .zero_o(zero), .neg_o(neg)
    );

    task automatic check(input string req, input logic [19:0] got, input logic [19:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    function automatic string tag_of(input logic [3:0] o);
        case (o)
            4'd0: return "R3";
            4'd1, 4'd2, 4'd3: return "R4";
            4'd4, 4'd6: return "R5";
            4'd5, 4'd7: return "R6";
            4'd8: return "R7";
            4'd9: return "R8";
            default: return "R3";
        endcase
    endfunction

    function automatic logic [19:0] to_xs3(input int v);
        logic [19:0] r = '0;
        int t = v;
        for (int k = 0; k < 5; k++) begin
            r[k*4 +: 4] = 4'((t % 10) + 3);
            t = t / 10;
        end
        return r;
    endfunction

    // Drive at the falling edge, sample 1 ns after the next rising edge.
    task automatic apply(input logic [3:0] o, input logic [19:0] aa, input logic [19:0] bb, input logic ci);
        @(negedge clk);
        op = o; a = aa; b = bb; cin = ci;
        @(posedge clk);
        #1;
    endtask

    task automatic check_out(input logic [3:0] o, input logic [19:0] er, input logic ec);
        string ctag;
        ctag = ((o <= 4'd3) || (o >= 4'd10)) ? "R9" : tag_of(o);
        check(tag_of(o), result, er);
        check(ctag, {19'd0, carry}, {19'd0, ec});
        check("R10 zero", {19'd0, zero}, {19'd0, (er == 20'd0)});
        check("R10 neg", {19'd0, neg}, {19'd0, er[19]});
    endtask

    initial begin
        #(8 * 100000);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int va, vb, s;
        logic [20:0] w;
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        check("R1 result", result, 20'd0);
        check("R1 flags", {17'd0, carry, zero, neg}, 20'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // Table of vectors
        for (int i = 0; i < NVEC; i++) begin
            apply(VECS[i].op, VECS[i].a, VECS[i].b, VECS[i].cin);
            check_out(VECS[i].op, VECS[i].res, VECS[i].c);
        end

        // R2: output holds until the next rising edge
        apply(4'd0, 20'h00000, 20'h55555, 1'b0);
        @(negedge clk);
        op = 4'd1; a = 20'hFFFFF; b = 20'h0F0F0;
        #2;
        check("R2 hold", result, 20'h55555);
        @(posedge clk);
        #1;
        check("R2 update", result, 20'h0F0F0);

        // R7/R8: random valid excess-three operands against integer model
        for (int i = 0; i < 40; i++) begin
            logic [3:0] o;
            logic ci;
            va = int'($urandom % 100000);
            vb = int'($urandom % 100000);
            ci = 1'($urandom);
            o  = (i % 2 == 0) ? 4'd8 : 4'd9;
            s  = va + vb + ((o == 4'd9 && ci) ? 1 : 0);
            apply(o, to_xs3(va), to_xs3(vb), ci);
            check_out(o, to_xs3(s % 100000), s >= 100000);
        end

        // R5/R6: random binary add-with-carry and subtract-with-carry
        for (int i = 0; i < 20; i++) begin
            logic [19:0] ra, rb;
            logic ci;
            ra = 20'($urandom);
            rb = 20'($urandom);
            ci = 1'($urandom);
            w = {1'b0, ra} + {1'b0, rb} + {20'd0, ci};
            apply(4'd6, ra, rb, ci);
            check_out(4'd6, w[19:0], w[20]);
            w = {1'b0, ra} + {1'b0, ~rb} + {20'd0, ci};
            apply(4'd7, ra, rb, ci);
            check_out(4'd7, w[19:0], w[20]);
        end

        // R1: reset during operation clears a nonzero result
        apply(4'd0, 20'h0, 20'h80001, 1'b0);
        @(negedge clk);
        rst_n = 1'b0;
        op = 4'd4; a = 20'hFFFFF; b = 20'hFFFFF;
        @(posedge clk);
        #1;
        check("R1 mid result", result, 20'd0);
        check("R1 mid flags", {17'd0, carry, zero, neg}, 20'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule